// File: doc/BRIEF.md
# External Data Memory Access Sequencer

This block carries out one byte-wide read or write to an external data memory over a shared, multiplexed address/data bus. A core-side request gives a 16-bit address, the write data, a direction flag and a port-2 source select. The sequencer then plays a fixed timeline of steps. It raises the address latch strobe, puts the low address byte on port 0 and drives port 2. It pulses the active-low read or write strobe. For a read, it captures the byte returned on port 0. For a write, it presents the data byte around the rising edge of the write strobe. A one-clock done pulse ends the access, and for a read it returns the byte.

The clock `clk` runs at twice the oscillator frequency. A timeline step lasts one oscillator period (two clocks) in normal mode and half a period (one clock) in double-speed mode, so the whole access shrinks by half. Each access takes 12 steps, which is one machine-cycle slot. While an access runs, `busy` is high. During that time the instruction-fetch program strobe and fetch address-latch pulses are held off the pins. Any new request is dropped.

Top module: `xmem_seq`

## Requirements
- R1: While `rst` is high and in the first clock after it, `busy`, `done` and `p0_oe` are 0, `rd_n` and `wr_n` are 1, and `rd_data` is 0.
- R2: A request (`req_valid`=1 while `busy`=0) is accepted at a rising edge. `busy` is 1 from the next clock until the clock in which `done` is 1, and in that clock `busy` is 0 again.
- R3: Number the steps 0 to 11 from acceptance. `ale` is 1 during steps 0 and 1 and 0 from step 2 onward.
- R4: For a read (`req_write`=0), `rd_n` is 0 during steps 5 to 10 and 1 at all other times. For a write, `wr_n` behaves the same way. The strobe not selected stays 1. The low pulse lasts 12 clocks in normal mode and 6 in double-speed mode.
- R5: During a read, `p0_oe` is 1 with `p0_out` = address bits 7:0 in steps 0 to 4, and `p0_oe` is 0 from step 5 onward. `rd_data` returns the value on `p0_in` in the last clock of step 8.
- R6: During a write, `p0_oe` is 1 in all 12 steps. `p0_out` carries address bits 7:0 in steps 0 to 3 and the write data in steps 4 to 11. The data is therefore valid one step before `wr_n` falls and held one step after it rises.
- R7: During an access, `p2_out` is address bits 15:8 when `req_p2reg`=0 and the `p2_reg` input when `req_p2reg`=1. When idle, it shows `p2_reg`.
- R8: While `busy`=1, `psen_n` is 1 and `ale` ignores `fetch_ale`. While idle, `ale` = `fetch_ale` and `psen_n` = NOT `fetch_psen`.
- R9: A request presented while `busy`=1 is ignored. The running access keeps its address, data and direction, and no extra access follows it.
- R10: `done` is a single-clock pulse in the clock after step 11. The access therefore lasts 24 clocks in normal mode and 12 in double-speed mode, counted from acceptance.
- R11: `dbl_speed` is sampled at acceptance. When it is 1, every step is one clock instead of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the oscillator rate |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_p2reg | input | 1 | 1 = port 2 shows `p2_reg`, 0 = high address byte |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| dbl_speed | input | 1 | Double-speed timing select |
| p2_reg | input | 8 | Port 2 register contents |
| fetch_ale | input | 1 | Fetch-side address latch request |
| fetch_psen | input | 1 | Fetch-side program strobe request (active high) |
| p0_in | input | 8 | Port 0 input pins |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Byte captured by the last read |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program store enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| p0_out | output | 8 | Port 0 output value |
| p0_oe | output | 1 | Port 0 drive enable |
| p2_out | output | 8 | Port 2 output value |

## Verification
Reads and writes run in both timing modes, and the bench compares every output in every clock against a step table. This separates a strobe placed one step early or late, a port-0 handover on the wrong step, and a pulse whose width does not scale with the mode. The read byte on `p0_in` is valid only during step 8, so a capture one clock early or late returns a wrong value. One access holds the fetch strobes active and sends a second request with other fields mid-access, which exposes leaking fetch pulses and requests that are not dropped. Port 2 is run with both sources so that a swapped select shows up.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    parameter int DATA_W = 8;
    localparam int ADDR_W = 2 * DATA_W;

    // Timeline, in steps (one oscillator period in normal mode).
    localparam int NUM_STEPS   = 12;
    localparam int STEP_W      = $clog2(NUM_STEPS);
    localparam int ALE_END     = 2;   // ale high for steps [0, ALE_END)
    localparam int DATA_START  = 4;   // write data replaces address here
    localparam int STRB_FIRST  = 5;   // strobe low from this step
    localparam int STRB_LAST   = 10;  // strobe low through this step
    localparam int SAMPLE_STEP = 8;   // read byte captured at end of this step
    localparam int LAST_STEP   = NUM_STEPS - 1;
    localparam int STRB_STEPS  = STRB_LAST - STRB_FIRST + 1;

    typedef struct packed {
        logic              write;
        logic              p2sel;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } xreq_t;

    function automatic logic in_window(input logic [STEP_W-1:0] s,
                                       input int lo, input int hi);
        return (int'(s) >= lo) && (int'(s) <= hi);
    endfunction

endpackage

// File: rtl/xmem_step_timer.sv
module xmem_step_timer
    import xmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              run,
    input  logic              dbl,
    output logic              step_en,
    output logic [STEP_W-1:0] step
);
    logic half;

    assign step_en = run && (dbl || half);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            half <= 1'b0;
            step <= '0;
        end else if (run) begin
            half <= ~half;
            if (step_en) begin
                step <= (step == STEP_W'(LAST_STEP)) ? '0 : step + 1'b1;
            end
        end
    end
endmodule

// File: rtl/xmem_strobe_map.sv
module xmem_strobe_map
    import xmem_pkg::*;
(
    input  logic              active,
    input  logic [STEP_W-1:0] step,
    input  xreq_t             req,
    input  logic [DATA_W-1:0] p2_reg,
    input  logic              fetch_ale,
    input  logic              fetch_psen,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] p0_out,
    output logic              p0_oe,
    output logic [DATA_W-1:0] p2_out
);
    logic strobe_on;

    always_comb begin
        strobe_on = active && in_window(step, STRB_FIRST, STRB_LAST);
        if (active) begin
            ale    = (int'(step) < ALE_END);
            psen_n = 1'b1;
        end else begin
            ale    = fetch_ale;
            psen_n = ~fetch_psen;
        end
        rd_n = ~(strobe_on && !req.write);
        wr_n = ~(strobe_on && req.write);
        if (!active)        p0_oe = 1'b0;
        else if (req.write) p0_oe = 1'b1;
        else                p0_oe = (int'(step) < STRB_FIRST);
        if (active && req.write && int'(step) >= DATA_START)
            p0_out = req.wdata;
        else
            p0_out = req.addr[DATA_W-1:0];
        if (active && !req.p2sel) p2_out = req.addr[ADDR_W-1:DATA_W];
        else                      p2_out = p2_reg;
    end
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
    import xmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_p2reg,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              dbl_speed,
    input  logic [DATA_W-1:0] p2_reg,
    input  logic              fetch_ale,
    input  logic              fetch_psen,
    input  logic [DATA_W-1:0] p0_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] p0_out,
    output logic              p0_oe,
    output logic [DATA_W-1:0] p2_out
);
    xreq_t             req_q;
    logic              dbl_q;
    logic              accept;
    logic              step_en;
    logic [STEP_W-1:0] step;

    assign accept = req_valid && !busy;

    xmem_step_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .run     (busy),
        .dbl     (dbl_q),
        .step_en (step_en),
        .step    (step)
    );

    xmem_strobe_map u_map (
        .active     (busy),
        .step       (step),
        .req        (req_q),
        .p2_reg     (p2_reg),
        .fetch_ale  (fetch_ale),
        .fetch_psen (fetch_psen),
        .ale        (ale),
        .psen_n     (psen_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .p0_out     (p0_out),
        .p0_oe      (p0_oe),
        .p2_out     (p2_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            rd_data <= '0;
            req_q   <= '0;
            dbl_q   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy  <= 1'b1;
                dbl_q <= dbl_speed;
                req_q <= '{write: req_write, p2sel: req_p2reg,
                           addr: req_addr, wdata: req_wdata};
            end else if (busy && step_en && step == STEP_W'(LAST_STEP)) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
            if (busy && step_en && !req_q.write && step == STEP_W'(SAMPLE_STEP))
                rd_data <= p0_in;
        end
    end

    // Strobe-width checker: counts clocks with a strobe low.
    localparam int CNT_W = $clog2(2 * STRB_STEPS + 2);
    logic [CNT_W-1:0] low_cnt;
    always_ff @(posedge clk) begin
        if (rst || (rd_n && wr_n)) low_cnt <= '0;
        else                       low_cnt <= low_cnt + 1'b1;
    end

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));
    p_strobe_width_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(rd_n) || $rose(wr_n)) |->
            (int'(low_cnt) == (dbl_q ? STRB_STEPS : 2 * STRB_STEPS)));
    p_psen_off_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> psen_n);
    p_p0_release_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_n) |-> !p0_oe);
    p_wdata_hold_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_n) |-> p0_oe);
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid) |=> (!busy || $stable(req_q)));
    p_ale_first_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ale);
endmodule

// File: tb/test_xmem_seq.sv
module test_xmem_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_p2reg, dbl_speed;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata, p2_reg, p0_in;
    logic        fetch_ale, fetch_psen;
    logic        busy, done, ale, psen_n, rd_n, wr_n, p0_oe;
    logic [7:0]  rd_data, p0_out, p2_out;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    xmem_seq i_xmem_seq (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One access, checked in every clock against the step table.
    task automatic run_access(input logic we, input logic p2sel,
                              input logic [15:0] addr, input logic [7:0] wd,
                              input logic [7:0] rdv, input logic dbl,
                              input logic fetch_on, input logic spam);
        int per = dbl ? 1 : 2;
        int total = 12 * per;
        @(negedge clk);
        req_valid = 1; req_write = we; req_p2reg = p2sel; req_addr = addr;
        req_wdata = wd; dbl_speed = dbl;
        fetch_ale = fetch_on; fetch_psen = fetch_on;
        @(posedge clk);
        for (int k = 0; k < total; k++) begin
            int s = k / per;
            @(negedge clk);
            if (spam) begin
                req_valid = 1; req_write = ~we; req_addr = ~addr;
                req_wdata = ~wd; dbl_speed = ~dbl;
            end else begin
                req_valid = 0;
            end
            if (k == total - 1) req_valid = 0;
            chk("R2", "busy", busy, 1);
            chk("R3", "ale", ale, s < 2);
            chk("R8", "psen_n", psen_n, 1);
            chk("R4", "rd_n", rd_n, !(!we && s >= 5 && s <= 10));
            chk("R4", "wr_n", wr_n, !(we && s >= 5 && s <= 10));
            if (we) begin
                chk("R6", "p0_oe", p0_oe, 1);
                chk("R6", "p0_out", p0_out, (s < 4) ? addr[7:0] : wd);
            end else begin
                chk("R5", "p0_oe", p0_oe, s < 5);
                if (s < 5) chk("R5", "p0_out", p0_out, addr[7:0]);
            end
            chk("R7", "p2_out", p2_out, p2sel ? p2_reg : addr[15:8]);
            chk("R11", "done_early", done, 0);
            p0_in = (s == 8) ? rdv : ~rdv;
        end
        @(negedge clk);
        chk("R10", "done", done, 1);
        chk("R2", "busy_end", busy, 0);
        if (!we) chk("R5", "rd_data", rd_data, rdv);
        fetch_ale = 0; fetch_psen = 0;
        @(negedge clk);
        chk("R10", "done_pulse", done, 0);
        chk("R9", "no_extra", busy, 0);
    endtask

    task automatic t_reset();
        rst = 1; req_valid = 0; req_write = 0; req_p2reg = 0; req_addr = 0;
        req_wdata = 0; dbl_speed = 0; p2_reg = 8'h5A; fetch_ale = 0;
        fetch_psen = 0; p0_in = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "rd_n", rd_n, 1);
        chk("R1", "wr_n", wr_n, 1);
        chk("R1", "p0_oe", p0_oe, 0);
        chk("R1", "rd_data", rd_data, 0);
    endtask

    task automatic t_idle_fetch();
        @(negedge clk);
        fetch_ale = 1; fetch_psen = 1;
        @(negedge clk);
        chk("R8", "idle_ale", ale, 1);
        chk("R8", "idle_psen", psen_n, 0);
        chk("R7", "idle_p2", p2_out, p2_reg);
        fetch_ale = 0; fetch_psen = 0;
        @(negedge clk);
        chk("R8", "idle_ale0", ale, 0);
        chk("R8", "idle_psen1", psen_n, 1);
    endtask

    initial begin
        t_reset();
        t_idle_fetch();
        run_access(0, 0, 16'h12C4, 8'h00, 8'hA7, 0, 0, 0); // R5 read normal
        run_access(1, 0, 16'h3B61, 8'hE2, 8'h00, 0, 0, 0); // R6 write normal
        run_access(0, 1, 16'h8F0D, 8'h00, 8'h3C, 1, 0, 0); // R11 read double
        run_access(1, 1, 16'h4477, 8'h19, 8'h00, 1, 0, 0); // R11 write double
        run_access(0, 0, 16'hC0DE, 8'h00, 8'h96, 0, 1, 1); // R8 R9 fetch+spam
        run_access(1, 0, 16'h0155, 8'hB4, 8'h00, 1, 1, 1); // R9 write spam
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule